// File: doc/BRIEF.md
# System Control Reset and A20 Port

This block is a byte-wide system control register sitting at a fixed I/O location. It offers software a fast way to reset the processor and a gate for address bit 20. A write that moves bit 0 from 0 to 1 fires one bounded, active-low pulse. The pulse goes to either the hard-reset line or the soft-init line, as a configuration select input chooses. Only a 0-to-1 transition fires, so software must clear bit 0 before it can request another pulse. A separate feature-enable input must be high for any pulse to fire.

Bit 1 is ORed with the keyboard-controller gate input to drive the address-bit-20 output. A read of bit 1 returns the state of that output, not the stored bit. The pulse width is a number of clock cycles derived from the clock frequency parameter. It is set to 1.25 µs nominal, which keeps it inside the allowed 1.0 to 1.5 µs window.

Top module: `sysctl_port`

## Requirements
- R1: After reset, the readback byte is 00h when the keyboard gate is low, and both pulse outputs are high.
- R2: With the feature enable high, a write that takes bit 0 from 0 to 1 drives the selected pulse output low from the clock edge that captures the write. It stays low for exactly PULSE_CYCLES = CLK_MHZ*5/4 cycles (156 cycles, 1.248 µs at 125 MHz).
- R3: Select input 0 steers the pulse to `cpuRstN` and 1 steers it to `cpuInitN`. The other output stays high.
- R4: A write of 1 to bit 0 while the stored bit 0 is already 1 produces no pulse. A write of 0 rearms it.
- R5: The select input is sampled when the pulse starts. A change to the select input during the pulse does not move or cut the pulse.
- R6: With the feature enable low, a 0-to-1 write of bit 0 stores the bit (it reads back as 1) but fires no pulse.
- R7: `a20Out` equals stored bit 1 OR `kbdA20Gate`.
- R8: Readback bit 1 returns the current value of `a20Out`.
- R9: Readback bits 7:2 are always 0, and writes to them are ignored.
- R10: A rearm-and-set write sequence issued while a pulse is active neither restarts nor lengthens that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Write strobe for the register, one cycle per write |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Readback: bit 0 is the stored reset bit, bit 1 is the A20 output, bits 7:2 are zero |
| cfgFastRstEn | input | 1 | Feature enable for the reset pulse |
| cfgPulseToInit | input | 1 | 0 = pulse on hard reset, 1 = pulse on soft init |
| kbdA20Gate | input | 1 | A20 gate from the keyboard controller |
| cpuRstN | output | 1 | Active-low hard-reset pulse |
| cpuInitN | output | 1 | Active-low soft-init pulse |
| a20Out | output | 1 | Address-bit-20 gate output |

## Verification
The assertions assume that `ioWr` is a single-cycle strobe with its data stable at the capturing edge. They also assume that the configuration inputs only change between clock edges. The bench drives every input at the falling edge, so each write is a clean one-cycle strobe. It toggles the select input in the middle of a pulse on purpose to exercise R5. Pulse widths are counted at the ports, one sample per falling edge.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ARM_BIT = 0;
  localparam int A20_BIT = 1;
  localparam logic [7:0] WR_MASK = 8'h03;

  typedef struct packed {
    logic wrCtl;    // load writable bits
    logic fire;     // start a pulse this edge
    logic fireSel;  // target: 0 hard reset, 1 soft init
  } sysctlStb_t;
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioWr,
  input  logic       wrArmVal,
  input  logic       armQ,
  input  logic       busy,
  input  logic       cfgFastRstEn,
  input  logic       cfgPulseToInit,
  output sysctlStb_t stb
);
  always_comb begin
    stb.wrCtl   = ioWr;
    stb.fire    = ioWr && wrArmVal && !armQ && cfgFastRstEn && !busy;
    stb.fireSel = cfgPulseToInit;
  end

  // R4
  rearm_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> !armQ);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.fire);
endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter int PULSE_CYCLES = 156,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
)(
  input  logic       clk,
  input  logic       rstN,
  input  sysctlStb_t stb,
  input  logic [7:0] ioWrData,
  input  logic       kbdA20Gate,
  output logic       armQ,
  output logic       busy,
  output logic [7:0] ioRdData,
  output logic       cpuRstN,
  output logic       cpuInitN,
  output logic       a20Out
);
  logic [7:0]       ctlQ;
  logic [CNT_W-1:0] cnt;
  logic             selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      busy <= 1'b0;
      cnt  <= '0;
      selQ <= 1'b0;
    end else begin
      if (stb.wrCtl) ctlQ <= ioWrData & WR_MASK;
      if (stb.fire) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(PULSE_CYCLES - 1);
        selQ <= stb.fireSel;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    armQ     = ctlQ[ARM_BIT];
    a20Out   = ctlQ[A20_BIT] | kbdA20Gate;
    ioRdData = ctlQ & WR_MASK;
    ioRdData[A20_BIT] = a20Out;
    cpuRstN  = !(busy && !selQ);
    cpuInitN = !(busy && selQ);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= CNT_W'(PULSE_CYCLES - 1)));

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!cpuRstN, !cpuInitN}));

  // R5
  no_retarget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuInitN) |=> cpuRstN);

  // R7
  kbd_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    kbdA20Gate |-> a20Out);

  // R9
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioRdData[7:2] == 6'd0);
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  localparam int PULSE_CYCLES = (CLK_MHZ * 5) / 4
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioWr,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  input  logic       cfgFastRstEn,
  input  logic       cfgPulseToInit,
  input  logic       kbdA20Gate,
  output logic       cpuRstN,
  output logic       cpuInitN,
  output logic       a20Out
);
  sysctlStb_t stb;
  logic       armQ;
  logic       busy;

  sysctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .wrArmVal(ioWrData[ARM_BIT]),
    .armQ(armQ), .busy(busy), .cfgFastRstEn(cfgFastRstEn),
    .cfgPulseToInit(cfgPulseToInit), .stb(stb)
  );

  sysctl_dpath #(.PULSE_CYCLES(PULSE_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWrData(ioWrData),
    .kbdA20Gate(kbdA20Gate), .armQ(armQ), .busy(busy),
    .ioRdData(ioRdData), .cpuRstN(cpuRstN), .cpuInitN(cpuInitN),
    .a20Out(a20Out)
  );

  // R6
  enable_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cpuRstN) || $fell(cpuInitN)) |-> $past(cfgFastRstEn));
endmodule

// File: tb/test_sysctl_port.sv
module test_sysctl_port;
  localparam int P = 156;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWr = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic cfgFastRstEn = 1'b1;
  logic cfgPulseToInit = 1'b0;
  logic kbdA20Gate = 1'b0;
  logic cpuRstN, cpuInitN, a20Out;
  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  sysctl_port #(.CLK_MHZ(125)) i_sysctl_port (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .cfgFastRstEn(cfgFastRstEn),
    .cfgPulseToInit(cfgPulseToInit), .kbdA20Gate(kbdA20Gate),
    .cpuRstN(cpuRstN), .cpuInitN(cpuInitN), .a20Out(a20Out)
  );

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); ioWr = 1'b1; ioWrData = d;
    @(negedge clk); ioWr = 1'b0;
  endtask

  // counts low samples on each line starting at the current negedge
  task automatic measure(output int rLow, output int iLow);
    rLow = 0; iLow = 0;
    for (int k = 0; k < 400; k++) begin
      if (!cpuRstN) rLow++;
      if (!cpuInitN) iLow++;
      @(negedge clk);
    end
  endtask

  task automatic tResetState();
    check("R1 rd", ioRdData, 0);
    check("R1 rst", cpuRstN, 1);
    check("R1 init", cpuInitN, 1);
  endtask

  task automatic tHardPulse();
    int r, i;
    cfgPulseToInit = 1'b0;
    wr(8'h01);
    measure(r, i);
    check("R2 width", r, P);
    check("R3 init idle", i, 0);
  endtask

  task automatic tRewriteOne();
    int r, i;
    wr(8'h01);
    measure(r, i);
    check("R4 no pulse", r + i, 0);
  endtask

  task automatic tInitAndSelChange();
    int r, i;
    wr(8'h00);
    cfgPulseToInit = 1'b1;
    wr(8'h01);
    fork
      measure(r, i);
      begin
        repeat (20) @(negedge clk);
        cfgPulseToInit = 1'b0;
      end
    join
    check("R3 init width", i, P);
    check("R5 rst idle", r, 0);
  endtask

  task automatic tDisabled();
    int r, i;
    wr(8'h00);
    cfgFastRstEn = 1'b0;
    wr(8'h01);
    measure(r, i);
    check("R6 no pulse", r + i, 0);
    check("R6 stored", ioRdData[0], 1);
    cfgFastRstEn = 1'b1;
    wr(8'h01);
    measure(r, i);
    check("R6 still armed", r + i, 0);
  endtask

  task automatic tRearmDuringPulse();
    int r, i;
    wr(8'h00);
    cfgPulseToInit = 1'b0;
    wr(8'h01);
    fork
      measure(r, i);
      begin
        repeat (50) @(negedge clk);
        ioWr = 1'b1; ioWrData = 8'h00; @(negedge clk);
        ioWrData = 8'h01; @(negedge clk);
        ioWr = 1'b0;
      end
    join
    check("R10 width", r, P);
    wr(8'h00);
  endtask

  task automatic tA20();
    kbdA20Gate = 1'b0;
    wr(8'h02);
    check("R7 bit on", a20Out, 1);
    check("R8 readback", ioRdData[1], 1);
    wr(8'h00);
    check("R7 bit off", a20Out, 0);
    check("R8 readback off", ioRdData[1], 0);
    kbdA20Gate = 1'b1;
    @(negedge clk);
    check("R7 kbd", a20Out, 1);
    check("R8 pin not bit", ioRdData[1], 1);
    kbdA20Gate = 1'b0;
  endtask

  task automatic tReserved();
    cfgFastRstEn = 1'b0;
    wr(8'hFC);
    check("R9 resv", ioRdData, 0);
    wr(8'hFE);
    check("R9 resv with a20", ioRdData, 2);
    wr(8'h00);
    cfgFastRstEn = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        tResetState();
        tHardPulse();
        tRewriteOne();
        tInitAndSelChange();
        tDisabled();
        tRearmDuringPulse();
        tA20();
        tReserved();
      end
      begin
        repeat (100000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule